// File: doc/BRIEF.md
# Cascadable Countdown Timer Bank

This block holds seven 8-bit down-counters that share one timer tick derived from the peripheral clock. The shared tick either fires on every clock or on every second clock, chosen by a single prescale bit. Timer 1 always counts the shared tick. Each of timers 2 to 7 counts either the shared tick or the underflow pulses of timer 1, so longer intervals can be built by cascading one stage behind timer 1.

Software reaches the bank over a plain byte-wide register bus with separate write and read strobes; there is no back-pressure, and a read returns its byte on the clock after the strobe. One interrupt request is raised while any timer has underflowed since the last status read, provided a nonzero priority level is programmed; the level travels beside the request. Everything runs on the one peripheral clock and uses clock enables, never derived clocks.

Top module: `timer_bank`

## Requirements
- R1: After reset the control byte is 0x00, the prescale bit is 1, every count and reload value is 0, every status flag is 0 and `irq_req` is 0.
- R2: With prescale bit 0 (address 0xA1, bit 0) set to 0 the shared tick fires on every clock; set to 1 it fires on every second clock. Bits 7:1 written to that address have no effect and read back as 0.
- R3: Each timer decrements by one per enabled tick; on an enabled tick while its count is 0 it loads its reload value and `tmr_pulse[k]` is high for exactly the following clock, so a reload value of V gives one pulse per V+1 enabled ticks.
- R4: Control byte (address 0xA4) bit j, for j in 2..7, selects the enable of timer j: 0 means the shared tick, 1 means the pulse on `tmr_pulse[0]` (timer 1 underflow).
- R5: The reload value of timer k (1..7) lives at address 0xA8+k; writing it does not alter the running count before that timer's next reload.
- R6: The status byte at address 0xA0 holds in bit k-1 a flag for timer k, set on the clock after its pulse. A read of the status byte returns the flags and clears them, except that a flag being set in the same cycle stays set.
- R7: `irq_req` is high exactly while some status flag is set and control bits 1:0 are nonzero; `irq_level` always shows control bits 1:0 (00 off, 01/10/11 levels 1/2/3).
- R8: `bus_rdata` carries, on the clock after `bus_rd`, the addressed byte (status, prescale, control or a reload value) and is 0 on every other clock and for unused addresses.
- R9: A change of the prescale bit changes the tick rate of every timer in the bank from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one clock after `bus_rd` |
| tmr_pulse | output | 7 | One-clock underflow pulse per timer, bit k-1 for timer k |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 2 | Programmed interrupt priority level |

## Verification
An underflow pulse appears one clock after the enabled tick that found a zero count, its status flag one clock after that, and the interrupt request follows the flag combinationally; a read byte is due one clock after the strobe. The bench drives inputs on the falling edge, advances a behavioural model on the rising edge with the same pre-edge inputs, and compares pulses, request, level and read data at the following falling edge, so each result is judged in the cycle it is due. Directed phases measure reload periods in clocks between pulses and read registers back to pin down reset values and ignored bits.

// File: rtl/timer_bank_pkg.sv
package timer_bank_pkg;
  localparam int unsigned TMR_N = 7;
  localparam int unsigned TMR_W = 8;
  localparam int unsigned BUS_W = 8;
  localparam logic [7:0] ADR_STATUS   = 8'hA0;
  localparam logic [7:0] ADR_PRESCALE = 8'hA1;
  localparam logic [7:0] ADR_CTRL     = 8'hA4;
  localparam logic [7:0] ADR_RELOAD0  = 8'hA9;
endpackage

// File: rtl/timer_bank_tick.sv
// Shared tick: every clock, or every second clock from a toggle flop.
module timer_bank_tick (
  input  logic clk,
  input  logic rst_n,
  input  logic div2,
  output logic tick
);
  logic half_q;

  always_ff @(posedge clk) begin
    if (!rst_n) half_q <= 1'b0;
    else        half_q <= ~half_q;
  end

  assign tick = div2 ? half_q : 1'b1;
endmodule

// File: rtl/timer_bank_down.sv
// One down-counter with reload and registered underflow pulse.
module timer_bank_down #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] reload,
  output logic         uf
);
  logic [W-1:0] cnt_q;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      uf    <= 1'b0;
    end else begin
      uf <= en && at_zero;
      if (en) cnt_q <= at_zero ? reload : cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/timer_bank_regs.sv
// Register file: control, prescale, reloads, status flags, read mux.
module timer_bank_regs
  import timer_bank_pkg::*;
#(
  parameter int unsigned N = TMR_N,
  parameter int unsigned W = TMR_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [BUS_W-1:0]    bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic [N-1:0]        uf,
  output logic [BUS_W-1:0]    ctrl_q,
  output logic                div2_q,
  output logic [N-1:0][W-1:0] reload_q,
  output logic [N-1:0]        flags_q,
  output logic                irq_req
);
  logic             stat_rd;
  logic [BUS_W-1:0] rd_mux;

  assign stat_rd = bus_rd && (bus_addr == ADR_STATUS);

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADR_STATUS)   rd_mux = BUS_W'(flags_q);
    if (bus_addr == ADR_PRESCALE) rd_mux = BUS_W'(div2_q);
    if (bus_addr == ADR_CTRL)     rd_mux = ctrl_q;
    for (int i = 0; i < N; i++) begin
      if (bus_addr == ADR_RELOAD0 + BUS_W'(i)) rd_mux = BUS_W'(reload_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      div2_q    <= 1'b1;
      flags_q   <= '0;
      bus_rdata <= '0;
    end else begin
      bus_rdata <= bus_rd ? rd_mux : '0;
      flags_q   <= (stat_rd ? '0 : flags_q) | uf;
      if (bus_wr && bus_addr == ADR_CTRL)     ctrl_q <= bus_wdata;
      if (bus_wr && bus_addr == ADR_PRESCALE) div2_q <= bus_wdata[0];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_rel
    always_ff @(posedge clk) begin
      if (!rst_n) reload_q[g] <= '0;
      else if (bus_wr && bus_addr == ADR_RELOAD0 + BUS_W'(g))
        reload_q[g] <= W'(bus_wdata);
    end
  end

  assign irq_req = (flags_q != '0) && (ctrl_q[1:0] != 2'b00);
endmodule

// File: rtl/timer_bank.sv
module timer_bank
  import timer_bank_pkg::*;
#(
  parameter int unsigned N = TMR_N,
  parameter int unsigned W = TMR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_addr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  output logic [N-1:0]     tmr_pulse,
  output logic             irq_req,
  output logic [1:0]       irq_level
);
  logic                shared_tick;
  logic                div2_q;
  logic [BUS_W-1:0]    ctrl_q;
  logic [N-1:0][W-1:0] reload_q;
  logic [N-1:0]        flags_q;
  logic [N-1:0]        tmr_en;

  timer_bank_tick u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .div2 (div2_q),
    .tick (shared_tick)
  );

  timer_bank_regs #(.N(N), .W(W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .uf       (tmr_pulse),
    .ctrl_q   (ctrl_q),
    .div2_q   (div2_q),
    .reload_q (reload_q),
    .flags_q  (flags_q),
    .irq_req  (irq_req)
  );

  // Timer 1 always counts the shared tick; the others may follow timer 1.
  for (genvar g = 0; g < N; g++) begin : g_tmr
    if (g == 0) begin : g_base
      assign tmr_en[g] = shared_tick;
    end else begin : g_casc
      assign tmr_en[g] = ctrl_q[g+1] ? tmr_pulse[0] : shared_tick;
    end
    timer_bank_down #(.W(W)) u_down (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (tmr_en[g]),
      .reload(reload_q[g]),
      .uf    (tmr_pulse[g])
    );
  end

  assign irq_level = ctrl_q[1:0];
endmodule

// File: rtl/timer_bank_chk.sv
module timer_bank_chk #(
  parameter int unsigned N = 7
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         div2,
  input logic [N-1:0] flags,
  input logic [N-1:0] pulse,
  input logic         irq_req,
  input logic [1:0]   irq_level,
  input logic         bus_rd,
  input logic [7:0]   bus_rdata
);
  a_r2_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (div2 && tick) |=> (!tick || !div2));

  a_r2_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
    !div2 |-> tick);

  a_r6_flag_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse != '0) |=> ((flags & $past(pulse)) == $past(pulse)));

  a_r7_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (flags != '0 && irq_level != 2'b00));

  a_r8_idle_read: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == 8'h00));
endmodule

bind timer_bank timer_bank_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (shared_tick),
  .div2     (div2_q),
  .flags    (flags_q),
  .pulse    (tmr_pulse),
  .irq_req  (irq_req),
  .irq_level(irq_level),
  .bus_rd   (bus_rd),
  .bus_rdata(bus_rdata)
);

// File: tb/sim_timer_bank.sv
module sim_timer_bank;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [6:0] tmr_pulse;
  logic       irq_req;
  logic [1:0] irq_level;

  int n_chk = 0;
  int n_fail = 0;

  timer_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tmr_pulse(tmr_pulse), .irq_req(irq_req), .irq_level(irq_level)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model, advanced on each rising edge.
  bit       m_half;
  bit       m_div2;
  int       m_ctrl;
  int       m_cnt[7];
  int       m_rel[7];
  bit [6:0] m_uf;
  bit [6:0] m_flags;
  int       m_rdata;

  always @(posedge clk) begin
    bit       tk;
    bit       en;
    bit [6:0] old_uf;
    bit [6:0] nuf;
    int       rv;
    if (!rst_n) begin
      m_half = 0; m_div2 = 1; m_ctrl = 0; m_uf = '0; m_flags = '0; m_rdata = 0;
      for (int i = 0; i < 7; i++) begin m_cnt[i] = 0; m_rel[i] = 0; end
    end else begin
      tk = m_div2 ? m_half : 1'b1;
      old_uf = m_uf;
      for (int i = 0; i < 7; i++) begin
        en = (i == 0) ? tk : ((((m_ctrl >> (i + 1)) & 1) == 1) ? old_uf[0] : tk);
        nuf[i] = en && (m_cnt[i] == 0);
        if (en) m_cnt[i] = (m_cnt[i] == 0) ? m_rel[i] : m_cnt[i] - 1;
      end
      rv = 0;
      if (bus_rd) begin
        if (bus_addr == 8'hA0) rv = m_flags;
        else if (bus_addr == 8'hA1) rv = m_div2;
        else if (bus_addr == 8'hA4) rv = m_ctrl;
        else if (bus_addr >= 8'hA9 && bus_addr <= 8'hAF) rv = m_rel[bus_addr - 8'hA9];
      end
      m_flags = ((bus_rd && bus_addr == 8'hA0) ? 7'd0 : m_flags) | old_uf;
      if (bus_wr) begin
        if (bus_addr == 8'hA1) m_div2 = bus_wdata[0];
        else if (bus_addr == 8'hA4) m_ctrl = bus_wdata;
        else if (bus_addr >= 8'hA9 && bus_addr <= 8'hAF) m_rel[bus_addr - 8'hA9] = bus_wdata;
      end
      m_half = !m_half;
      m_uf = nuf;
      m_rdata = rv;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Continuous comparison on every falling edge once out of reset.
  always @(negedge clk) begin
    if (rst_n) begin
      check("R3/R4/R9 tmr_pulse", tmr_pulse, m_uf);
      check("R7 irq_req", irq_req, (m_flags != 0) && ((m_ctrl & 3) != 0));
      check("R7 irq_level", irq_level, m_ctrl & 3);
      check("R6/R8 bus_rdata", bus_rdata, m_rdata);
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic wait_pulse0();
    do @(negedge clk); while (!tmr_pulse[0]);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int n;
    repeat (4) @(negedge clk);
    check("R1 irq_req in reset", irq_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    bus_read(8'hA1, d); check("R1 prescale reset", d, 8'h01);
    bus_read(8'hA4, d); check("R1 control reset", d, 8'h00);
    bus_read(8'hAC, d); check("R1 reload reset", d, 8'h00);
    bus_read(8'hB3, d); check("R8 unused address", d, 8'h00);

    // R2: upper bits ignored, bit 0 = 0 gives full rate.
    bus_write(8'hA1, 8'hFE);
    bus_read(8'hA1, d); check("R2 prescale readback", d, 8'h00);

    // R3: reload 4 at full rate gives a 5-clock period.
    bus_write(8'hA9, 8'h04);
    wait_pulse0(); wait_pulse0();
    n = 0;
    do begin @(negedge clk); n++; end while (!tmr_pulse[0]);
    check("R3 period reload 4", n, 5);

    // R5: rewrite reload just after a pulse; current period unchanged.
    bus_write(8'hA9, 8'h09);
    n = 1;
    while (!tmr_pulse[0]) begin @(negedge clk); n++; end
    check("R5 period before reload", n, 5);
    n = 0;
    do begin @(negedge clk); n++; end while (!tmr_pulse[0]);
    check("R3 period reload 9", n, 10);

    // R4: timer 2 follows timer 1, priority 2.
    bus_write(8'hAA, 8'h01);
    bus_write(8'hA4, 8'h06);
    repeat (80) @(negedge clk);
    bus_read(8'hA0, d);
    bus_read(8'hA0, d);
    repeat (30) @(negedge clk);

    // R7: priority 00 masks the request.
    bus_write(8'hA4, 8'h04);
    check("R7 masked irq", irq_req, 0);

    // R9: back to half rate for all timers.
    bus_write(8'hA1, 8'h01);
    repeat (100) @(negedge clk);

    // Mixed cascade and reload values with periodic status reads.
    bus_write(8'hA4, 8'hAB);
    for (int k = 0; k < 7; k++) bus_write(8'hA9 + 8'(k), 8'(3 * k + 2));
    for (int r = 0; r < 40; r++) begin
      repeat (25) @(negedge clk);
      bus_read(8'hA0, d);
      if (r == 20) bus_write(8'hA1, 8'h00);
    end
    bus_write(8'hA4, 8'hFF);
    repeat (300) @(negedge clk);
    bus_read(8'hA0, d);
    @(negedge clk);
    finish_run();
  end
endmodule